// File: doc/BRIEF.md
# Skip-Branch Word Processor Core

A small processor for a 32-bit ISA of ten instructions, organised as a multicycle machine. It holds a program counter, sixteen 32-bit general registers and an add/NAND arithmetic unit. It fetches from and stores to a single word-addressed memory through one synchronous port. That port has a 16-bit address, 32-bit write data, a write enable and 32-bit read data. Read data shows up one cycle after the address. Each instruction takes three cycles: fetch, decode and execute. A load adds a fourth cycle for write-back.

The ISA has no compare-and-branch instruction. Conditional flow uses a skip instruction, which jumps over the next word when a register comparison holds. The skip is paired with an unconditional PC-relative jump. The instruction set also covers register and immediate arithmetic, load and store, PC-relative address generation, jump-and-link and halt. After a halt the core asserts `halted` and stays idle until reset.

Top module: `wordskip_core`

## Requirements
- R1: Synchronous active-low reset sets PC to 0, clears every register and deasserts `halted`; the first fetch after reset reads address 0.
- R2: The opcode is instruction bits [31:28] (0000 add, 0001 NAND, 0010 add-immediate, 0011 load, 0100 store, 0101 jump, 0110 jump-and-link, 0111 halt, 1000 skip, 1001 address-generate). The destination is bits [27:24], the first source bits [23:20] and the second source bits [3:0]. Add writes src1+src2 and NAND writes ~(src1 & src2).
- R3: Add-immediate writes src1 plus the 20-bit field [19:0] sign-extended to 32 bits.
- R4: Register 0 always reads as zero and a write to it has no effect.
- R5: Load and store use the address base (bits [23:20]) + sign-extended offset, and only the low 16 bits reach the memory port. A store writes the register named in bits [27:24].
- R6: PC advances by one word at fetch, and jump sets PC to that incremented PC plus the sign-extended offset.
- R7: Address-generate writes incremented PC + sign-extended offset into the register in bits [27:24] and does not change control flow.
- R8: Jump-and-link writes the incremented PC into the register in bits [27:24], then loads PC from the register in bits [23:20].
- R9: Skip with mode field [27:24] = 0 jumps over the next instruction when the two sources are equal.
- R10: Skip with mode 1 jumps over the next instruction when src1 < src2 as signed values, and any other mode has no effect.
- R11: Halt raises `halted`. After that the core makes no further fetch or store, and `halted` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Word address to memory |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, one cycle per store |
| mem_rdata | input | 32 | Read data, valid the cycle after the address |
| halted | output | 1 | High once a halt has executed |

## Verification
The hardest cases to observe from the ports are the instructions that only change control flow: a taken skip, a signed less-than between operands of opposite sign, a skip whose mode is unused, and the jump-and-link target. The program places a trap store at each word that must be passed over. The scoreboard holds the exact ordered list of stores the program must make, so a trap store, or a missing store in the wrong place, shows up as a mismatch. Address truncation is driven with a base of 0x10000, and the cleared registers are checked by running a second program after a new reset.

// File: rtl/wsc_pkg.sv
// Package: shared constants for the skip-branch core.
// Assumes a fixed 32-bit instruction word with the field layout below.
package wsc_pkg;
    localparam int ILEN    = 32;
    localparam int OPC_HI  = 31;
    localparam int OPC_LO  = 28;
    localparam int FA_LO   = 24;   // destination / store source / skip mode
    localparam int FB_LO   = 20;   // first source / base / jump target
    localparam int FC_LO   = 0;    // second source

    localparam logic [3:0] OP_ADD  = 4'b0000;
    localparam logic [3:0] OP_NAND = 4'b0001;
    localparam logic [3:0] OP_ADDI = 4'b0010;
    localparam logic [3:0] OP_LW   = 4'b0011;
    localparam logic [3:0] OP_SW   = 4'b0100;
    localparam logic [3:0] OP_GOTO = 4'b0101;
    localparam logic [3:0] OP_JALR = 4'b0110;
    localparam logic [3:0] OP_HALT = 4'b0111;
    localparam logic [3:0] OP_SKP  = 4'b1000;
    localparam logic [3:0] OP_LEA  = 4'b1001;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_LOAD,
        ST_HALT
    } core_state_e;
endpackage

// File: rtl/wsc_regfile.sv
// Register file: NREG x XLEN, two combinational read ports, one write port.
// Assumes entry 0 is hard zero; writes to it are dropped at the write port.
module wsc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic [IW-1:0]   rb_addr,
    output logic [XLEN-1:0] rb_data,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data
);
    logic [XLEN-1:0] regs_q [NREG];

    // Register update: clear on reset, otherwise write any entry but zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_en && wr_addr != '0) begin
            regs_q[wr_addr] <= wr_data;
        end
    end

    // Read ports: entry 0 always presents zero.
    always_comb begin
        ra_data = (ra_addr == '0) ? '0 : regs_q[ra_addr];
        rb_data = (rb_addr == '0) ? '0 : regs_q[rb_addr];
    end

    assert_zero_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (regs_q[0] == '0));
endmodule

// File: rtl/wsc_alu.sv
// Arithmetic unit: add or NAND of two operands, plus equal and signed-less
// compare flags. Purely combinational; assumes the caller selects operands.
module wsc_alu #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opnd_x,
    input  logic [XLEN-1:0] opnd_y,
    input  logic            use_nand,
    output logic [XLEN-1:0] result,
    output logic            is_eq,
    output logic            is_lt
);
    // Result and compare flags.
    always_comb begin
        result = use_nand ? ~(opnd_x & opnd_y) : (opnd_x + opnd_y);
        is_eq  = (opnd_x == opnd_y);
        is_lt  = ($signed(opnd_x) < $signed(opnd_y));
    end
endmodule

// File: rtl/wordskip_core.sv
// Top: multicycle core. FETCH drives PC, DECODE latches the instruction and
// bumps PC, EXEC performs the operation, LOAD writes back load data.
// Assumes memory returns read data one cycle after the address.
module wordskip_core
    import wsc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 16,
    parameter int AW    = 16,
    parameter int IMM_W = 20,
    localparam int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            halted
);
    core_state_e     st_q;
    logic [XLEN-1:0] pc_q;
    logic [ILEN-1:0] ir_q;

    logic [3:0]      opc;
    logic [IW-1:0]   fld_a, fld_b, fld_c, rb_sel;
    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] ra_data, rb_data, alu_x, alu_y, alu_res;
    logic            alu_eq, alu_lt, skip_hit;
    logic            wb_en;
    logic [XLEN-1:0] wb_data;

    // Field extraction and sign extension of the immediate.
    always_comb begin
        opc   = ir_q[OPC_HI:OPC_LO];
        fld_a = ir_q[FA_LO +: IW];
        fld_b = ir_q[FB_LO +: IW];
        fld_c = ir_q[FC_LO +: IW];
        imm_x = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    end

    // Operand selection, write-back and memory port control.
    always_comb begin
        rb_sel   = (opc == OP_SW) ? fld_a : fld_c;
        alu_x    = (opc == OP_GOTO || opc == OP_LEA) ? pc_q : ra_data;
        alu_y    = (opc == OP_ADD || opc == OP_NAND || opc == OP_SKP) ? rb_data : imm_x;
        skip_hit = (opc == OP_SKP) &&
                   ((fld_a == IW'(0) && alu_eq) || (fld_a == IW'(1) && alu_lt));
        wb_en    = 1'b0;
        wb_data  = alu_res;
        if (st_q == ST_EXEC) begin
            case (opc)
                OP_ADD, OP_NAND, OP_ADDI, OP_LEA: wb_en = 1'b1;
                OP_JALR: begin
                    wb_en   = 1'b1;
                    wb_data = pc_q;
                end
                default: wb_en = 1'b0;
            endcase
        end else if (st_q == ST_LOAD) begin
            wb_en   = 1'b1;
            wb_data = mem_rdata;
        end
        mem_we    = (st_q == ST_EXEC) && (opc == OP_SW);
        mem_wdata = rb_data;
        mem_addr  = ((st_q == ST_EXEC) && (opc == OP_LW || opc == OP_SW))
                    ? alu_res[AW-1:0] : pc_q[AW-1:0];
        halted    = (st_q == ST_HALT);
    end

    // Sequencer: state, instruction register and program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_FETCH;
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            case (st_q)
                ST_FETCH:  st_q <= ST_DECODE;
                ST_DECODE: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + XLEN'(1);
                    st_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    case (opc)
                        OP_GOTO: pc_q <= alu_res;
                        OP_JALR: pc_q <= ra_data;
                        OP_SKP:  if (skip_hit) pc_q <= pc_q + XLEN'(1);
                        default: pc_q <= pc_q;
                    endcase
                    if (opc == OP_LW)        st_q <= ST_LOAD;
                    else if (opc == OP_HALT) st_q <= ST_HALT;
                    else                     st_q <= ST_FETCH;
                end
                ST_LOAD:  st_q <= ST_FETCH;
                default:  st_q <= ST_HALT;
            endcase
        end
    end

    wsc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (fld_b),
        .ra_data (ra_data),
        .rb_addr (rb_sel),
        .rb_data (rb_data),
        .wr_en   (wb_en),
        .wr_addr (fld_a),
        .wr_data (wb_data)
    );

    wsc_alu #(.XLEN(XLEN)) u_alu (
        .opnd_x   (alu_x),
        .opnd_y   (alu_y),
        .use_nand (opc == OP_NAND),
        .result   (alu_res),
        .is_eq    (alu_eq),
        .is_lt    (alu_lt)
    );

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_q)));
    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
    assert_fetch_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECODE) |=> (pc_q == $past(pc_q) + XLEN'(1)));
    assert_skip_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && opc == OP_SKP && fld_a == IW'(0) && ra_data == rb_data)
        |=> (pc_q == $past(pc_q) + XLEN'(1)));
    assert_link_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && opc == OP_JALR) |=> (pc_q == $past(ra_data)));
endmodule

// File: tb/wordskip_core_tb_top.sv
`timescale 1ns/1ps
module wordskip_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_we, halted;

    always #2.5 clk = ~clk;

    wordskip_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
    );

    // Synchronous memory model, 1024 words, indexed by low address bits.
    logic [31:0] mem [1024];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [15:0] a;
        logic [31:0] d;
        string       tag;
    } store_t;
    store_t sb_q[$];

    // Driver side: queue an expected store.
    task automatic expect_store(input logic [15:0] a, input logic [31:0] d, input string tag);
        store_t s;
        s.a = a; s.d = d; s.tag = tag;
        sb_q.push_back(s);
    endtask

    // Monitor: compare each observed store against the queue head.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11 unexpected store", {16'h0, mem_addr}, 32'h0);
            end else begin
                store_t s;
                s = sb_q.pop_front();
                check(mem_addr == s.a, {s.tag, " addr"}, {16'h0, mem_addr}, {16'h0, s.a});
                check(mem_wdata == s.d, {s.tag, " data"}, mem_wdata, s.d);
            end
        end
    end

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] fa,
                                        input logic [3:0] fb, input logic [19:0] lo);
        return {op, fa, fb, lo};
    endfunction

    localparam logic [19:0] TRAP = 20'h001FF;

    task automatic load_prog1();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem[0]  = enc(4'h2, 4'd1, 4'd0, 20'd5);          // r1 = 5
        mem[1]  = enc(4'h2, 4'd2, 4'd0, 20'hFFFFD);      // r2 = -3
        mem[2]  = enc(4'h0, 4'd3, 4'd1, 20'd2);          // r3 = r1 + r2
        mem[3]  = enc(4'h4, 4'd3, 4'd0, 20'h100);
        mem[4]  = enc(4'h1, 4'd4, 4'd1, 20'd1);          // r4 = ~(r1&r1)
        mem[5]  = enc(4'h4, 4'd4, 4'd0, 20'h101);
        mem[6]  = enc(4'h2, 4'd0, 4'd1, 20'd7);          // write to r0
        mem[7]  = enc(4'h4, 4'd0, 4'd0, 20'h102);
        mem[8]  = enc(4'h4, 4'd2, 4'd0, 20'h103);
        mem[9]  = enc(4'h3, 4'd5, 4'd0, 20'h103);        // r5 = mem[0x103]
        mem[10] = enc(4'h2, 4'd5, 4'd5, 20'd1);
        mem[11] = enc(4'h4, 4'd5, 4'd0, 20'h104);
        mem[12] = enc(4'h9, 4'd6, 4'd0, 20'd4);          // r6 = 13 + 4
        mem[13] = enc(4'h4, 4'd6, 4'd0, 20'h105);
        mem[14] = enc(4'h5, 4'd0, 4'd0, 20'd1);          // jump over 15
        mem[15] = enc(4'h4, 4'd1, 4'd0, TRAP);
        mem[16] = enc(4'h8, 4'd0, 4'd1, 20'd1);          // equal: skip 17
        mem[17] = enc(4'h4, 4'd1, 4'd0, TRAP);
        mem[18] = enc(4'h8, 4'd0, 4'd1, 20'd2);          // not equal
        mem[19] = enc(4'h4, 4'd1, 4'd0, 20'h106);
        mem[20] = enc(4'h8, 4'd1, 4'd2, 20'd1);          // -3 < 5: skip 21
        mem[21] = enc(4'h4, 4'd1, 4'd0, TRAP);
        mem[22] = enc(4'h8, 4'd1, 4'd1, 20'd2);          // 5 < -3 false
        mem[23] = enc(4'h4, 4'd2, 4'd0, 20'h107);
        mem[24] = enc(4'h8, 4'd2, 4'd1, 20'd1);          // mode 2: no effect
        mem[25] = enc(4'h4, 4'd3, 4'd0, 20'h108);
        mem[26] = enc(4'h9, 4'd7, 4'd0, 20'd4);          // r7 = 31
        mem[27] = enc(4'h6, 4'd8, 4'd7, 20'd0);          // r8 = 28, pc = 31
        mem[28] = enc(4'h4, 4'd1, 4'd0, TRAP);
        mem[29] = enc(4'h4, 4'd1, 4'd0, TRAP);
        mem[30] = enc(4'h4, 4'd1, 4'd0, TRAP);
        mem[31] = enc(4'h4, 4'd8, 4'd0, 20'h109);
        mem[32] = enc(4'h2, 4'd11, 4'd0, 20'h10000);     // r11 = 0x10000
        mem[33] = enc(4'h4, 4'd1, 4'd11, 20'h110);       // addr 0x10110
        mem[34] = enc(4'h7, 4'd0, 4'd0, 20'd0);          // halt
        mem[35] = enc(4'h4, 4'd1, 4'd0, TRAP);
    endtask

    task automatic wait_halt();
        int wd = 0;
        while (!halted && wd < 2000) begin
            @(negedge clk);
            wd++;
        end
        check(halted, "R11 watchdog halt reached", {31'h0, halted}, 32'h1);
    endtask

    initial begin
        load_prog1();
        repeat (3) @(negedge clk);
        check(halted == 1'b0, "R1 halted low in reset", {31'h0, halted}, 32'h0);
        check(mem_we == 1'b0, "R1 no store in reset", {31'h0, mem_we}, 32'h0);
        check(mem_addr == 16'h0, "R1 fetch address zero", {16'h0, mem_addr}, 32'h0);

        expect_store(16'h100, 32'h00000002, "R2 add");
        expect_store(16'h101, 32'hFFFFFFFA, "R2 nand");
        expect_store(16'h102, 32'h00000000, "R4 zero register");
        expect_store(16'h103, 32'hFFFFFFFD, "R3 sign-extended immediate");
        expect_store(16'h104, 32'hFFFFFFFE, "R5 load");
        expect_store(16'h105, 32'd17,       "R7 address generate");
        expect_store(16'h106, 32'd5,        "R9 equal skip / R6 jump");
        expect_store(16'h107, 32'hFFFFFFFD, "R10 signed less");
        expect_store(16'h108, 32'h00000002, "R10 unused mode");
        expect_store(16'h109, 32'd28,       "R8 link");
        expect_store(16'h110, 32'd5,        "R5 address truncation");
        rst_n = 1'b1;

        wait_halt();
        repeat (20) @(negedge clk);
        check(halted == 1'b1, "R11 halted sticky", {31'h0, halted}, 32'h1);
        check(sb_q.size() == 0, "R11 all stores seen", sb_q.size(), 32'h0);
        check(mem_we == 1'b0, "R11 no store after halt", {31'h0, mem_we}, 32'h0);

        rst_n = 1'b0;
        sb_q.delete();
        @(negedge clk);
        @(negedge clk);
        check(halted == 1'b0, "R1 reset clears halted", {31'h0, halted}, 32'h0);
        mem[0] = enc(4'h4, 4'd5, 4'd0, 20'h120);
        mem[1] = enc(4'h4, 4'd8, 4'd0, 20'h121);
        mem[2] = enc(4'h7, 4'd0, 4'd0, 20'd0);
        expect_store(16'h120, 32'h0, "R1 register cleared r5");
        expect_store(16'h121, 32'h0, "R1 register cleared r8");
        rst_n = 1'b1;
        wait_halt();
        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R1 second run stores seen", sb_q.size(), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule